// File: doc/BRIEF.md
# Host Mailbox Queue with Data-Waiting Interrupt

This block holds a small first-in first-out queue of 32-bit words. A producer adds words to it from one side, and a host processor drains them over a simple register bus. The producer presents a word with a one-cycle enqueue strobe. The host reads the words back through a pop window, and the window answers at any of four word-aligned aliases. The host can also look at the oldest word without removing it, read full and empty flags from a status word, and control a level interrupt through a config word. The interrupt stays high for as long as words are waiting and the host has enabled it.

The bus takes a read strobe, a write strobe, an 8-bit byte address and write data. Read data is registered and appears on the clock after the read strobe. A pop of an empty queue returns the marker 0xFFFFFFFF and changes nothing.

Top module: `mailbox_regs`

## Requirements
- R1: A read at byte offset 0x80, 0x84, 0x88 or 0x8C removes the oldest queued word and returns it, so words come out in the order they were enqueued.
- R2: A pop read while the queue is empty returns 0xFFFFFFFF and leaves the queue unchanged.
- R3: A read at offset 0x90 returns the oldest word without removing it. When the queue is empty it returns 0xFFFFFFFF.
- R4: A read at offset 0x98 returns a status word. Bit 31 is 1 exactly when the queue holds 8 words. Bit 30 is 1 exactly when it holds none. All other bits are 0.
- R5: A read at offset 0x9C returns a config word. Bit 0 is the interrupt enable. Bit 4 is the data-pending flag, which is 1 whenever the queue is not empty. All other bits read 0.
- R6: A write to offset 0x9C loads write-data bit 0 into the enable. Every other write-data bit has no effect.
- R7: The irq output is 1 exactly when the data-pending flag and the enable are both 1. It changes on the same clock edge as the queue count and the enable.
- R8: After reset the queue is empty, the enable is 0, irq is 0 and a peek returns 0xFFFFFFFF.
- R9: A read at any other offset, including an unaligned one such as 0x81, returns 0 and has no side effect. A write at any offset other than 0x9C is ignored.
- R10: The queue holds 8 words. An enqueue while it is full, with no pop in the same cycle, is dropped.
- R11: An enqueue and a pop in the same cycle are both carried out, even when the queue is full. On an empty queue the pop returns 0xFFFFFFFF and the enqueued word is kept.
- R12: Read data is registered. bus_rdata takes its new value on the clock edge that samples the read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| enq_valid | input | 1 | Producer enqueue strobe |
| enq_data | input | 32 | Producer word |
| irq | output | 1 | Level interrupt: data waiting and enabled |

## Verification
A corrupted count or pointer shows up at the ports on the very next status, peek or pop read. It appears as a wrong full or empty flag, a word out of order, or a marker where data was expected. It also shows on irq one clock after the faulty edge. A bad enable bit shows at once on irq, and at the next config read. A dropped or duplicated word from a simultaneous enqueue and pop only becomes visible when the queue is drained, so the bench drains the queue completely after every such case.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_POP,
    SEL_PEEK,
    SEL_STAT,
    SEL_CFG
  } mbx_sel_e;

  localparam logic [7:0] OFS_POP_BASE = 8'h80;
  localparam logic [7:0] OFS_PEEK     = 8'h90;
  localparam logic [7:0] OFS_STAT     = 8'h98;
  localparam logic [7:0] OFS_CFG      = 8'h9C;

  localparam int BIT_FULL    = 31;
  localparam int BIT_EMPTY   = 30;
  localparam int BIT_EN      = 0;
  localparam int BIT_PENDING = 4;
endpackage

// File: rtl/mbx_dec.sv
module mbx_dec
  import mbx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  output mbx_sel_e      sel
);
  logic [7:0] low;
  assign low = addr[7:0];

  if (AW > 8) begin : g_hi
    logic hi_unused;
    assign hi_unused = ^addr[AW-1:8];
  end

  always_comb begin
    sel = SEL_NONE;
    if (low[7:4] == OFS_POP_BASE[7:4] && low[1:0] == 2'b00) sel = SEL_POP;
    else if (low == OFS_PEEK) sel = SEL_PEEK;
    else if (low == OFS_STAT) sel = SEL_STAT;
    else if (low == OFS_CFG)  sel = SEL_CFG;
  end
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int          W     = 32,
  parameter int          DEPTH = 8,
  parameter logic [W-1:0] MARK = '1,
  localparam int         PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int         CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          pop_ok, push_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign cnt_nxt = cnt + CW'(push_ok) - CW'(pop_ok);
  assign head    = empty ? MARK : mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      if (push_ok) wr_ptr <= bump(wr_ptr);
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r2_empty_pop_hold: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (cnt == '0));
  a_r10_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);
  a_r11_both: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> $stable(cnt));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we,
  input  logic en_bit,
  input  logic busy_now,
  input  logic busy_nxt,
  output logic en,
  output logic irq
);
  logic en_nxt;
  assign en_nxt = cfg_we ? en_bit : en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      irq <= 1'b0;
    end else begin
      en  <= en_nxt;
      irq <= en_nxt && busy_nxt;
    end
  end

  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (en && busy_now));
  a_r6_en_load: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (en == $past(en_bit)));
endmodule

// File: rtl/mailbox_regs.sv
module mailbox_regs
  import mbx_pkg::*;
#(
  parameter int           AW    = 8,
  parameter int           W     = 32,
  parameter int           DEPTH = 8,
  parameter logic [W-1:0] MARK  = '1,
  localparam int          CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          enq_valid,
  input  logic [W-1:0]  enq_data,
  output logic          irq
);
  mbx_sel_e      sel;
  logic [W-1:0]  head;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          full, empty, en, pop, cfg_we;
  logic          wdata_unused;

  assign wdata_unused = ^bus_wdata[W-1:1];
  assign pop    = bus_rd && (sel == SEL_POP);
  assign cfg_we = bus_wr && (sel == SEL_CFG);

  mbx_dec #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  mbx_fifo #(.W(W), .DEPTH(DEPTH), .MARK(MARK)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (enq_valid),
    .push_data (enq_data),
    .pop       (pop),
    .head      (head),
    .cnt       (cnt),
    .cnt_nxt   (cnt_nxt),
    .full      (full),
    .empty     (empty)
  );

  mbx_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .en_bit   (bus_wdata[0]),
    .busy_now (!empty),
    .busy_nxt (cnt_nxt != '0),
    .en       (en),
    .irq      (irq)
  );

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_POP, SEL_PEEK: rd_mux = head;
      SEL_STAT: begin
        rd_mux[BIT_FULL]  = full;
        rd_mux[BIT_EMPTY] = empty;
      end
      SEL_CFG: begin
        rd_mux[BIT_EN]      = en;
        rd_mux[BIT_PENDING] = !empty;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  a_r2_empty_pop_marker: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (bus_rdata == MARK));
endmodule

// File: tb/test_mailbox_regs.sv
module test_mailbox_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        enq_valid = 1'b0;
  logic [31:0] enq_data = '0;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [31:0] MK = 32'hFFFF_FFFF;
  localparam logic [31:0] ST_EMPTY = 32'h4000_0000;
  localparam logic [31:0] ST_FULL  = 32'h8000_0000;

  always #10 clk = ~clk;

  mailbox_regs i_mailbox_regs (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .enq_valid(enq_valid), .enq_data(enq_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge clk); enq_valid = 1'b1; enq_data = v;
    @(negedge clk); enq_valid = 1'b0;
  endtask

  task automatic pushpop(input logic [31:0] v, output logic [31:0] d);
    @(negedge clk); enq_valid = 1'b1; enq_data = v; bus_rd = 1'b1; bus_addr = 8'h80;
    @(negedge clk); enq_valid = 1'b0; bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R8 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h98, d); chk("R8 status empty", d, ST_EMPTY);
    rd(8'h9C, d); chk("R8 config clear", d, 32'h0);
    rd(8'h90, d); chk("R8 peek marker", d, MK);
  endtask

  task automatic t_order;
    logic [31:0] d;
    push(32'hA1); push(32'hB2); push(32'hC3);
    rd(8'h90, d); chk("R3 peek head", d, 32'hA1);
    rd(8'h90, d); chk("R3 peek no remove", d, 32'hA1);
    rd(8'h98, d); chk("R4 status partial", d, 32'h0);
    rd(8'h80, d); chk("R1 pop 0x80", d, 32'hA1);
    rd(8'h84, d); chk("R1 pop 0x84", d, 32'hB2);
    rd(8'h8C, d); chk("R1 pop 0x8C", d, 32'hC3);
    rd(8'h98, d); chk("R4 status drained", d, ST_EMPTY);
  endtask

  task automatic t_empty_pop;
    logic [31:0] d;
    rd(8'h88, d); chk("R2 empty pop marker", d, MK);
    rd(8'h98, d); chk("R2 still empty", d, ST_EMPTY);
    push(32'hD4);
    rd(8'h80, d); chk("R2 next word intact", d, 32'hD4);
  endtask

  task automatic t_full;
    logic [31:0] d;
    for (int i = 0; i < 9; i++) push(32'h100 + i);
    rd(8'h98, d); chk("R4 status full", d, ST_FULL);
    rd(8'h9C, d); chk("R5 pending, disabled", d, 32'h10);
    for (int i = 0; i < 8; i++) begin
      rd(8'h80, d); chk("R10 drain order", d, 32'h100 + i);
    end
    rd(8'h80, d); chk("R10 ninth dropped", d, MK);
  endtask

  task automatic t_config;
    logic [31:0] d;
    wr(8'h9C, 32'hFFFF_FFFE);
    rd(8'h9C, d); chk("R6 only bit0 taken", d, 32'h0);
    push(32'hE5);
    chk("R7 irq off when disabled", {31'b0, irq}, 32'h0);
    rd(8'h9C, d); chk("R5 pending bit", d, 32'h10);
    wr(8'h9C, 32'h1);
    chk("R7 irq on", {31'b0, irq}, 32'h1);
    rd(8'h9C, d); chk("R5 enable and pending", d, 32'h11);
    rd(8'h80, d); chk("R1 pop", d, 32'hE5);
    chk("R7 irq drops with last pop", {31'b0, irq}, 32'h0);
    push(32'hE6);
    chk("R7 irq rises with push", {31'b0, irq}, 32'h1);
    wr(8'h9C, 32'h0);
    chk("R7 irq off after disable", {31'b0, irq}, 32'h0);
    rd(8'h80, d); chk("R1 pop", d, 32'hE6);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    push(32'hF7);
    rd(8'h94, d); chk("R9 read 0x94", d, 32'h0);
    rd(8'h00, d); chk("R9 read 0x00", d, 32'h0);
    rd(8'h81, d); chk("R9 unaligned read", d, 32'h0);
    wr(8'h80, 32'h1); wr(8'h90, 32'h1); wr(8'h98, 32'h1);
    rd(8'h9C, d); chk("R9 writes ignored, enable 0", d, 32'h10);
    rd(8'h90, d); chk("R9 head untouched", d, 32'hF7);
    rd(8'h80, d); chk("R9 pop", d, 32'hF7);
    rd(8'h98, d); chk("R9 empty after", d, ST_EMPTY);
  endtask

  task automatic t_simul;
    logic [31:0] d;
    pushpop(32'h55, d); chk("R11 empty pop marker", d, MK);
    rd(8'h90, d); chk("R11 push kept", d, 32'h55);
    for (int i = 1; i < 8; i++) push(32'h200 + i);
    rd(8'h98, d); chk("R4 full", d, ST_FULL);
    pushpop(32'h299, d); chk("R11 pop at full", d, 32'h55);
    rd(8'h98, d); chk("R11 still full", d, ST_FULL);
    for (int i = 1; i < 8; i++) begin
      rd(8'h84, d); chk("R11 drain", d, 32'h200 + i);
    end
    rd(8'h88, d); chk("R11 pushed word last", d, 32'h299);
    rd(8'h98, d); chk("R11 empty", d, ST_EMPTY);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    rd(8'h98, d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h94;
    #2 chk("R12 old data before edge", bus_rdata, ST_EMPTY);
    @(negedge clk); bus_rd = 1'b0;
    chk("R12 new data after edge", bus_rdata, 32'h0);
    @(negedge clk);
    chk("R12 held", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_order();
    t_empty_pop();
    t_full();
    t_config();
    t_unmapped();
    t_simul();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule